// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block sits between a simple synchronous host port and an asynchronous 256K x 16 dynamic memory with a multiplexed 9-bit address bus. The host offers one request at a time with a valid/ready handshake. A request carries a read/write flag, an 18-bit word address, 16 bits of write data and two byte enables. The controller turns each request into a RAS/CAS sequence on the memory pins and returns read data with a one-cycle valid pulse.

After an access the row stays open. Further requests to the same row are served as page-mode column cycles without a new RAS cycle. The row is closed when a request targets another row, when the external refresh requester asks for the bus, or when the open-row timer nears the longest RAS low time allowed. Byte masking uses separate upper and lower column strobes. Every timing quantity is a parameter counted in clock cycles.

Refresh itself is done elsewhere. This block only hands the idle, precharged bus to the refresh requester between accesses.

Top module: `pgdram_ctrl`

## Requirements
- R1: The word address is split with the row in bits 17:9 and the column in bits 8:0. The row is on the address pins when RAS falls, and the column is on them when the column strobes fall.
- R2: The row address is on the pins from the cycle before RAS falls until T_RAH cycles after. The column address is on the pins from the cycle before the strobes fall and stays unchanged while any strobe is low.
- R3: Byte enable bit 1 selects the upper strobe and data bits 15:8. Bit 0 selects the lower strobe and bits 7:0. A disabled byte is not written, and it reads back as zero. With both enables clear, no strobe falls.
- R4: A write is an early write. WE is low and the data bus output enable is asserted one cycle before the strobes fall, and they stay so while the strobes are low. OE stays high throughout the write.
- R5: OE is driven low only in read column cycles, with WE high and the data bus output enable released.
- R6: Read data is taken after both access times have elapsed. These are T_RAC cycles from the RAS fall on the first access of a row, and T_CAC cycles from the strobe fall on every access. The data is returned with a valid pulse exactly one cycle wide.
- R7: Successive requests to the open row are served without a new RAS cycle.
- R8: A request to another row closes the open row. RAS is then high for at least T_RP cycles before it falls again.
- R9: Column strobes fall only while RAS is low. Both strobes are high for at least T_CP cycles between column cycles, and column cycles in one page start at least T_PC cycles apart.
- R10: RAS is never low for more than RAS_MAX cycles. An open row with no traffic is closed by the timer.
- R11: The refresh grant is given only while the row is closed and precharged and both strobes are high. No host request is accepted while refresh is requested.
- R12: After reset RAS, both strobes, WE and OE are high, the data bus is not driven, no response is pending and a request can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted at this clock edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, row in 17:9, column in 8:0 |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 upper byte, bit 0 lower byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 16 | Read data, disabled bytes zero |
| ref_req | input | 1 | External refresh requester wants the bus |
| ref_gnt | output | 1 | Bus is idle and precharged for refresh |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data driven toward the memory |
| dram_dq_oe | output | 1 | Enable for the data bus drivers |
| dram_dq_in | input | 16 | Data returned by the memory |

## Verification
The hardest case to reach is the open-row timer running out. It only happens after a long string of same-row accesses, or a long idle gap, with the row held open. The bench builds the controller with a short RAS_MAX and issues a long run of same-row reads. It then leaves the row idle and checks that extra RAS cycles appear without any overlong RAS low period. A behavioural memory model in the bench serves data only once the access times have passed, so reading too early returns a wrong word. The model also counts hold, precharge and page-cycle violations on the pins.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROWSET,
    ST_ROW,
    ST_COLSET,
    ST_COL,
    ST_CPRE,
    ST_OPEN,
    ST_PRECH
  } pg_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pgdram_countdown.sv
module pgdram_countdown #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)            cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/pgdram_ras_timer.sv
module pgdram_ras_timer #(
  parameter int RAS_MAX = 2500,
  parameter int LIMIT   = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low,
  output logic expired
);

  localparam int W = $clog2(RAS_MAX + 2);
  localparam logic [W-1:0] SAT = W'(RAS_MAX + 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = !ras_low || (cnt_q != SAT);

  always_comb begin
    cnt_d = cnt_q;
    if (!ras_low) cnt_d = '0;
    else          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q > W'(LIMIT));

endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
  import pgdram_pkg::*;
#(
  parameter int ROW_W   = 9,
  parameter int COL_W   = 9,
  parameter int DATA_W  = 16,
  parameter int T_RAH   = 3,
  parameter int T_RAC   = 15,
  parameter int T_CAC   = 4,
  parameter int T_CP    = 3,
  parameter int T_PC    = 10,
  parameter int T_RP    = 10,
  parameter int RAS_MAX = 2500
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [1:0]             req_be,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  input  logic                   ref_req,
  output logic                   ref_gnt,
  output logic                   dram_ras_n,
  output logic                   dram_ucas_n,
  output logic                   dram_lcas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [ROW_W-1:0]       dram_addr,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);

  localparam int ADDR_W    = ROW_W + COL_W;
  localparam int HALF      = DATA_W / 2;
  localparam int N_FIRST   = imax(imax(T_CAC, T_RAC - T_RAH - 1), 1);
  localparam int N_PAGE    = imax(imax(T_CAC, T_PC - T_CP - 2), 1);
  localparam int PAGE_SPAN = N_PAGE + T_CP + 2;
  localparam int LIMIT     = RAS_MAX - PAGE_SPAN - 1;
  localparam int CNT_MAX   = imax(imax(N_FIRST, T_RP), imax(T_RAH, T_CP));
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  pg_state_e            state_q, state_d;
  logic [ROW_W-1:0]     row_q;
  logic [COL_W-1:0]     col_q;
  logic                 wr_q, first_q;
  logic [1:0]           be_q;
  logic [DATA_W-1:0]    wdata_q;
  logic                 rsp_valid_q;
  logic [DATA_W-1:0]    rsp_rdata_q;

  logic                 cnt_load, cnt_done, expired, same_row, accept, capture;
  logic [CNT_W-1:0]     cnt_val;

  pgdram_countdown #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .load(cnt_load), .load_val(cnt_val), .done(cnt_done)
  );

  pgdram_ras_timer #(.RAS_MAX(RAS_MAX), .LIMIT(LIMIT)) u_ras_tmr (
    .clk(clk), .rst_n(rst_n_s), .ras_low(!dram_ras_n), .expired(expired)
  );

  assign same_row  = (req_addr[ADDR_W-1:COL_W] == row_q);
  assign req_ready = !ref_req &&
                     ((state_q == ST_IDLE) || ((state_q == ST_OPEN) && same_row && !expired));
  assign accept    = req_valid && req_ready;
  assign capture   = (state_q == ST_COL) && cnt_done && !wr_q;

  // next-state
  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_ROWSET;
      ST_ROWSET: begin
        state_d  = ST_ROW;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(T_RAH - 1);
      end
      ST_ROW:    if (cnt_done) state_d = ST_COLSET;
      ST_COLSET: begin
        state_d  = ST_COL;
        cnt_load = 1'b1;
        cnt_val  = first_q ? CNT_W'(N_FIRST - 1) : CNT_W'(N_PAGE - 1);
      end
      ST_COL: if (cnt_done) begin
        state_d  = ST_CPRE;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(T_CP - 1);
      end
      ST_CPRE:   if (cnt_done) state_d = ST_OPEN;
      ST_OPEN: begin
        if (accept) begin
          state_d = ST_COLSET;
        end else if (ref_req || expired || req_valid) begin
          state_d  = ST_PRECH;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(T_RP - 1);
        end
      end
      ST_PRECH:  if (cnt_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q     <= ST_IDLE;
      row_q       <= '0;
      col_q       <= '0;
      wr_q        <= 1'b0;
      first_q     <= 1'b0;
      be_q        <= '0;
      wdata_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= capture;
      if (accept) begin
        row_q   <= req_addr[ADDR_W-1:COL_W];
        col_q   <= req_addr[COL_W-1:0];
        wr_q    <= req_write;
        be_q    <= req_be;
        wdata_q <= req_wdata;
        first_q <= (state_q == ST_IDLE);
      end
      if (capture) begin
        rsp_rdata_q <= {be_q[1] ? dram_dq_in[DATA_W-1:HALF] : {HALF{1'b0}},
                        be_q[0] ? dram_dq_in[HALF-1:0]      : {HALF{1'b0}}};
      end
    end
  end

  // pin decode
  logic row_phase, col_phase, ras_on;
  assign ras_on    = (state_q == ST_ROW) || (state_q == ST_COLSET) || (state_q == ST_COL) ||
                     (state_q == ST_CPRE) || (state_q == ST_OPEN);
  assign row_phase = (state_q == ST_IDLE) || (state_q == ST_ROWSET) ||
                     (state_q == ST_ROW)  || (state_q == ST_PRECH);
  assign col_phase = (state_q == ST_COLSET) || (state_q == ST_COL);

  assign dram_ras_n  = !ras_on;
  assign dram_addr   = row_phase ? row_q : ROW_W'(col_q);
  assign dram_ucas_n = !((state_q == ST_COL) && be_q[1]);
  assign dram_lcas_n = !((state_q == ST_COL) && be_q[0]);
  assign dram_we_n   = !(col_phase && wr_q);
  assign dram_oe_n   = !((state_q == ST_COL) && !wr_q);
  assign dram_dq_oe  = col_phase && wr_q;
  assign dram_dq_out = wdata_q;
  assign ref_gnt     = (state_q == ST_IDLE) && ref_req && rst_n_s;
  assign rsp_valid   = rsp_valid_q;
  assign rsp_rdata   = rsp_rdata_q;

endmodule

// File: rtl/pgdram_ctrl_chk.sv
module pgdram_ctrl_chk #(
  parameter int RAS_MAX = 2500
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ras_n,
  input logic       ucas_n,
  input logic       lcas_n,
  input logic       we_n,
  input logic       oe_n,
  input logic       dq_oe,
  input logic [8:0] addr,
  input logic       ref_gnt,
  input logic       ref_req,
  input logic       req_ready,
  input logic       rsp_valid
);

  localparam int W = $clog2(RAS_MAX + 2);

  logic          cas_hi;
  logic [W-1:0]  low_cnt;
  assign cas_hi = ucas_n && lcas_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         low_cnt <= '0;
    else if (ras_n)                     low_cnt <= '0;
    else if (low_cnt != W'(RAS_MAX + 1)) low_cnt <= low_cnt + 1'b1;
  end

  assert_oe_only_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n && !dq_oe));

  assert_cas_inside_ras_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_hi |-> !ras_n);

  assert_gnt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (ras_n && cas_hi));

  assert_no_accept_on_ref_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !req_ready);

  assert_rsp_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_col_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_hi && !$past(cas_hi)) |-> $stable(addr));

  assert_we_early_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_hi) && !we_n) |-> (!$past(we_n) && $past(dq_oe) && oe_n));

  assert_ras_max_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (low_cnt < W'(RAS_MAX)));

endmodule

bind pgdram_ctrl pgdram_ctrl_chk #(.RAS_MAX(RAS_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .ucas_n(dram_ucas_n),
  .lcas_n(dram_lcas_n), .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_oe(dram_dq_oe),
  .addr(dram_addr), .ref_gnt(ref_gnt), .ref_req(ref_req), .req_ready(req_ready),
  .rsp_valid(rsp_valid)
);

// File: tb/pgdram_ctrl_test.sv
module pgdram_ctrl_test;

  localparam int T_RAH = 3, T_RAC = 15, T_CAC = 4, T_CP = 3, T_PC = 10, T_RP = 10;
  localparam int RAS_MAX = 120;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid, ref_gnt;
  logic [15:0] rsp_rdata, dq_out, dq_in;
  logic        ras_n, ucas_n, lcas_n, we_n, oe_n, dq_oe;
  logic [8:0]  addr;

  always #2 clk = ~clk;

  pgdram_ctrl #(.T_RAH(T_RAH), .T_RAC(T_RAC), .T_CAC(T_CAC), .T_CP(T_CP),
                .T_PC(T_PC), .T_RP(T_RP), .RAS_MAX(RAS_MAX)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_ras_n(ras_n), .dram_ucas_n(ucas_n), .dram_lcas_n(lcas_n), .dram_we_n(we_n),
    .dram_oe_n(oe_n), .dram_addr(addr), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe),
    .dram_dq_in(dq_in)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  function automatic logic [7:0] hidx(input logic [8:0] r, input logic [8:0] c);
    return {r[8], r[2:0], c[8], c[2:0]};
  endfunction

  logic [15:0] mdl_mem [0:255];
  logic [15:0] exp_mem [0:255];
  logic        p_ras, p_cas, p_we, p_dqoe;
  logic [8:0]  p_addr, mrow, mcol;
  int ras_cnt, hi_cnt, cas_cnt, cashi, pc_cnt, ras_falls;
  int v2, v4, v5, v8, v9, v10;
  logic cas_any, data_ok;

  assign cas_any = !(ucas_n && lcas_n);
  assign data_ok = !ras_n && cas_any && we_n && !oe_n &&
                   (ras_cnt + 1 >= T_RAC) && (cas_cnt + 1 >= T_CAC);
  assign dq_in = data_ok ? {ucas_n ? 8'hEE : mdl_mem[hidx(mrow, mcol)][15:8],
                            lcas_n ? 8'hEE : mdl_mem[hidx(mrow, mcol)][7:0]} : 16'hDEAD;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_ras <= 1'b1; p_cas <= 1'b0; p_we <= 1'b1; p_dqoe <= 1'b0; p_addr <= '0;
      mrow <= '0; mcol <= '0;
      ras_cnt <= 0; hi_cnt <= T_RP; cas_cnt <= 0; cashi <= T_CP; pc_cnt <= T_PC;
      ras_falls <= 0; v2 <= 0; v4 <= 0; v5 <= 0; v8 <= 0; v9 <= 0; v10 <= 0;
    end else begin
      if (ras_n) begin
        ras_cnt <= 0;
        hi_cnt  <= hi_cnt + 1;
        if (!p_ras && ras_cnt > RAS_MAX) v10 <= v10 + 1;
      end else if (p_ras) begin
        ras_falls <= ras_falls + 1;
        if (hi_cnt < T_RP) v8 <= v8 + 1;
        if (addr != p_addr) v2 <= v2 + 1;
        mrow <= addr; hi_cnt <= 0; ras_cnt <= 1;
      end else begin
        ras_cnt <= ras_cnt + 1;
        if (ras_cnt < T_RAH && addr != mrow) v2 <= v2 + 1;
      end
      if (cas_any && !p_cas) begin
        if (ras_n || cashi < T_CP || pc_cnt < T_PC) v9 <= v9 + 1;
        if (ras_cnt < T_RAH || addr != p_addr) v2 <= v2 + 1;
        mcol <= addr; cas_cnt <= 1; cashi <= 0; pc_cnt <= 1;
        if (!we_n) begin
          if (p_we || !p_dqoe || !dq_oe || !oe_n) v4 <= v4 + 1;
          if (!ucas_n) mdl_mem[hidx(mrow, addr)][15:8] <= dq_out[15:8];
          if (!lcas_n) mdl_mem[hidx(mrow, addr)][7:0]  <= dq_out[7:0];
        end
      end else if (cas_any) begin
        cas_cnt <= cas_cnt + 1; pc_cnt <= pc_cnt + 1;
        if (addr != mcol) v2 <= v2 + 1;
      end else begin
        cas_cnt <= 0; cashi <= cashi + 1; pc_cnt <= pc_cnt + 1;
      end
      if (!ras_n && p_ras) pc_cnt <= T_PC;
      if (!oe_n && (!we_n || dq_oe)) v5 <= v5 + 1;
      if (dq_oe && we_n) v5 <= v5 + 1;
      p_ras <= ras_n; p_cas <= cas_any; p_we <= we_n; p_dqoe <= dq_oe; p_addr <= addr;
    end
  end

  // ---------------- host tasks ----------------
  task automatic issue(input logic wr, input logic [8:0] r, input logic [8:0] c,
                       input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {r, c}; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [8:0] r, input logic [8:0] c, input logic [15:0] d,
                    input logic [1:0] be);
    issue(1'b1, r, c, d, be);
    if (be[1]) exp_mem[hidx(r, c)][15:8] = d[15:8];
    if (be[0]) exp_mem[hidx(r, c)][7:0]  = d[7:0];
  endtask

  task automatic rd(input logic [8:0] r, input logic [8:0] c, input logic [1:0] be,
                    input string tag);
    logic [15:0] e;
    e = {be[1] ? exp_mem[hidx(r, c)][15:8] : 8'h00, be[0] ? exp_mem[hidx(r, c)][7:0] : 8'h00};
    issue(1'b0, r, c, 16'h0, be);
    for (int n = 0; n < 300 && !rsp_valid; n++) @(negedge clk);
    chk(tag, rsp_rdata, e);
    @(negedge clk);
    chk("R6 valid pulse one cycle", rsp_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R12 actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  logic [8:0] rows [0:4];
  logic [8:0] cols [0:3];
  int snap;

  initial begin
    for (int i = 0; i < 256; i++) begin
      mdl_mem[i] = 16'(i * 16'h0123) ^ 16'h5A5A;
      exp_mem[i] = 16'(i * 16'h0123) ^ 16'h5A5A;
    end
    rows[0] = 9'h000; rows[1] = 9'h001; rows[2] = 9'h005; rows[3] = 9'h1FF; rows[4] = 9'h100;
    cols[0] = 9'h000; cols[1] = 9'h003; cols[2] = 9'h1FF; cols[3] = 9'h104;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk("R12 ras_n", ras_n, 1); chk("R12 ucas_n", ucas_n, 1); chk("R12 lcas_n", lcas_n, 1);
    chk("R12 we_n", we_n, 1);   chk("R12 oe_n", oe_n, 1);     chk("R12 dq_oe", dq_oe, 0);
    chk("R12 rsp_valid", rsp_valid, 0); chk("R12 req_ready", req_ready, 1);

    // R1: sweep rows and columns, full-word writes then reads
    foreach (rows[i]) foreach (cols[j])
      wr(rows[i], cols[j], {rows[i][7:0] ^ 8'h3C, cols[j][7:0] + 8'(i * 16 + j)}, 2'b11);
    foreach (rows[i]) foreach (cols[j]) rd(rows[i], cols[j], 2'b11, "R1 address split readback");

    // R3: every write enable pattern against every read enable pattern
    for (int wb = 0; wb < 4; wb++) begin
      wr(9'h005, 9'h003, 16'hC0DE + 16'(wb * 16'h1111), 2'(wb));
      for (int rb = 0; rb < 4; rb++) rd(9'h005, 9'h003, 2'(rb), "R3 byte mask");
    end

    // R7: same row stays open
    snap = ras_falls;
    for (int k = 0; k < 4; k++) rd(9'h001, cols[k], 2'b11, "R7 page read");
    chk("R7 one RAS cycle for page burst", ras_falls - snap, 1);

    // R8: alternating rows force new RAS cycles
    snap = ras_falls;
    for (int k = 0; k < 4; k++) rd((k % 2 == 0) ? 9'h000 : 9'h1FF, cols[k], 2'b11, "R8 row change read");
    chk("R8 RAS cycle per row change", ras_falls - snap, 4);

    // R10: long same-row run hits the timer
    snap = ras_falls;
    for (int k = 0; k < 14; k++) rd(9'h100, cols[k % 4], 2'b11, "R10 long page read");
    chk("R10 timer forced extra RAS cycle", (ras_falls - snap) >= 2, 1);
    repeat (RAS_MAX + 20) @(negedge clk);
    chk("R10 idle row closed", ras_n, 1);

    // R11: refresh while a row is open and a request waits
    rd(9'h005, 9'h000, 2'b11, "R11 open row before refresh");
    @(negedge clk);
    ref_req = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = {9'h005, 9'h000}; req_be = 2'b11;
    begin
      int n = 0;
      while (!ref_gnt && n < 60) begin
        chk("R11 no accept while refresh pending", req_ready, 0);
        @(negedge clk); n++;
      end
    end
    chk("R11 grant given", ref_gnt, 1);
    chk("R11 ras high on grant", ras_n, 1);
    chk("R11 strobes high on grant", {ucas_n, lcas_n}, 2'b11);
    snap = ras_falls;
    repeat (5) @(negedge clk);
    chk("R11 bus quiet during grant", ras_falls - snap, 0);
    ref_req = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 0; n < 300 && !rsp_valid; n++) @(negedge clk);
    chk("R11 request served after refresh", rsp_rdata, exp_mem[hidx(9'h005, 9'h000)]);
    repeat (10) @(negedge clk);

    // pin-level protocol counters from the model
    chk("R2 address hold violations", v2, 0);
    chk("R4 early write violations", v4, 0);
    chk("R5 output enable violations", v5, 0);
    chk("R8 precharge violations", v8, 0);
    chk("R9 strobe timing violations", v9, 0);
    chk("R10 RAS low too long", v10, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule